// File: doc/BRIEF.md
# Serial-Loaded Segmented DAC Front End

This block is the digital front end of a 16-bit voltage-output converter with a serial input. A host writes a data word over a 3-wire serial port: an active-low chip select, a serial clock and a data line. The block samples all three pins with a faster system clock. While chip select is low it shifts in data bits on serial clock rising edges, most significant bit first. When chip select returns high after a complete word, the word is copied into the DAC register.

The DAC register drives the switch controls of a segmented converter. Its top nibble is decoded into fifteen thermometer-coded segment enables. Its low twelve bits drive the binary ladder switches one to one. A single-cycle `updated` pulse marks every load. An asynchronous power-on reset clears the register to code 0, which gives a 0 V unipolar output.

The system clock must run at least four times faster than the serial clock. Each serial pin passes through a two-flop synchronizer before any edge is detected.

Top module: `serial_dac_front`

## Requirements
- R1: A word is shifted in most significant bit first. After a frame of exactly 16 bits, the DAC register holds those 16 bits, with the first bit sent at position 15.
- R2: Data is taken only on a serial clock rising edge while chip select is low. Serial clock and data activity while chip select is high leaves the outputs unchanged and produces no `updated` pulse.
- R3: The DAC register loads only on a chip select rising edge, and only if at least 16 bits were received since the preceding chip select falling edge.
- R4: If chip select rises after fewer than 16 bits, the DAC register keeps its previous value and no `updated` pulse is produced.
- R5: If more than 16 bits arrive in one frame, the last 16 bits received are loaded.
- R6: Every chip select falling edge restarts the bit count. Bits from an aborted short frame do not count toward the next frame, so a following 8-bit frame does not load.
- R7: `segEn[k-1]` is high exactly when bits 15:12 of the DAC register, read as an unsigned value, are at least k (k = 1..15). Value v therefore gives v active enables, filled from bit 0 upward.
- R8: `ladder[i]` equals bit i of the DAC register for i = 0..11.
- R9: While reset is asserted and after it is released, before any load, `segEn` and `ladder` are all zero and `updated` is low.
- R10: `updated` is high for exactly one system clock cycle for each load, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| csN | input | 1 | Serial chip select, active low, frames a word |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, most significant bit first |
| segEn | output | 15 | Thermometer-coded segment enables from the top nibble |
| ladder | output | 12 | Binary ladder switch controls from the low 12 bits |
| updated | output | 1 | One-cycle pulse when the DAC register loads |

## Verification
The bench sends frames of random length with random data, mixed with directed cases. A frame one bit short must be dropped; a design that loads on any chip select rise would instead show a partial, misaligned code. Frames longer than 16 bits catch a design that freezes after the first 16 bits rather than keeping the last 16. An aborted frame followed by an 8-bit frame catches a counter that is not cleared on the chip select falling edge. Serial clock toggling with chip select high catches a design that shifts regardless of select. Codes at every top nibble, including 0 and 15, expose off-by-one and bit-order errors in the thermometer decode.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic clearFrame;
    logic shiftBit;
    logic loadReg;
  } dacStrobe_t;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[0] <= RESET_VAL;
          else       stage[0] <= asyncIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= RESET_VAL;
          else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  output dacStrobe_t strobe
);
  logic             csPrev, sclkPrev;
  logic [CNT_W-1:0] bitCount, countBase;
  logic             csFall, csRise, sclkRise;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end

  assign csFall   = csPrev && !csS;
  assign csRise   = !csPrev && csS;
  assign sclkRise = sclkS && !sclkPrev;

  always_comb begin
    strobe.clearFrame = csFall;
    strobe.shiftBit   = sclkRise && !csS;
    strobe.loadReg    = csRise && (bitCount == CNT_W'(WORD_W));
  end

  assign countBase = strobe.clearFrame ? '0 : bitCount;

  // Saturating bit counter, restarted by each new frame
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) bitCount <= '0;
    else if (strobe.shiftBit) begin
      if (countBase != CNT_W'(WORD_W)) bitCount <= countBase + 1'b1;
      else                             bitCount <= countBase;
    end else if (strobe.clearFrame) bitCount <= '0;
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SEG_BITS = 4,
  localparam int LADDER_W = WORD_W - SEG_BITS,
  localparam int SEG_N = (1 << SEG_BITS) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdiS,
  input  dacStrobe_t          strobe,
  output logic [SEG_N-1:0]    segEn,
  output logic [LADDER_W-1:0] ladder,
  output logic                updated
);
  logic [WORD_W-1:0]   shiftReg, shiftBase, dacReg;
  logic [SEG_BITS-1:0] topNib;

  assign shiftBase = strobe.clearFrame ? '0 : shiftReg;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftBit)   shiftReg <= {shiftBase[WORD_W-2:0], sdiS};
    else if (strobe.clearFrame) shiftReg <= '0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      dacReg  <= '0;
      updated <= 1'b0;
    end else begin
      updated <= strobe.loadReg;
      if (strobe.loadReg) dacReg <= shiftReg;
    end

  assign topNib = dacReg[WORD_W-1 -: SEG_BITS];
  assign ladder = dacReg[LADDER_W-1:0];

  generate
    for (genvar k = 1; k <= SEG_N; k++) begin : g_therm
      assign segEn[k-1] = (topNib >= SEG_BITS'(k));
    end
  endgenerate
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import dacfe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SEG_BITS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LADDER_W = WORD_W - SEG_BITS,
  localparam int SEG_N = (1 << SEG_BITS) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  output logic [SEG_N-1:0]    segEn,
  output logic [LADDER_W-1:0] ladder,
  output logic                updated
);
  logic [2:0] pinSync;
  logic       csSync;
  dacStrobe_t strobe;

  dacfe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sclk, sdi}), .syncOut(pinSync)
  );

  assign csSync = pinSync[2];

  dacfe_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csSync), .sclkS(pinSync[1]), .strobe(strobe)
  );

  dacfe_datapath #(.WORD_W(WORD_W), .SEG_BITS(SEG_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .sdiS(pinSync[0]), .strobe(strobe),
    .segEn(segEn), .ladder(ladder), .updated(updated)
  );
endmodule

// File: rtl/serial_dac_front_chk.sv
module serial_dac_front_chk #(
  parameter int SEG_N = 15,
  parameter int LADDER_W = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                csSync,
  input logic [SEG_N-1:0]    segEn,
  input logic [LADDER_W-1:0] ladder,
  input logic                updated
);
  // R7
  thermo_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((segEn + 1'b1) & segEn) == '0);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    updated |=> !updated);

  // R3
  load_on_cs_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    updated |-> $past(csSync));

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updated |-> ($stable(segEn) && $stable(ladder)));

  // R9
  always @(posedge clk)
    if (!rstN) reset_clear_chk: assert (segEn == '0 && ladder == '0 && !updated);
endmodule

bind serial_dac_front serial_dac_front_chk #(.SEG_N(SEG_N), .LADDER_W(LADDER_W)) u_chk (
  .clk(clk), .rstN(rstN), .csSync(csSync),
  .segEn(segEn), .ladder(ladder), .updated(updated)
);

// File: tb/serial_dac_front_test.sv
`timescale 1ns/1ps
module serial_dac_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [14:0] segEn;
  logic [11:0] ladder;
  logic        updated;

  int runCount = 0, failCount = 0;
  int pulseCount = 0, highCycles = 0;
  logic prevUpd = 1'b0;
  logic [15:0] expCode = 16'h0000;
  bit finished = 0;

  serial_dac_front uut (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
                        .segEn(segEn), .ladder(ladder), .updated(updated));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (updated) highCycles++;
    if (updated && !prevUpd) pulseCount++;
    prevUpd = updated;
  end

  function automatic logic [14:0] thermo(input logic [3:0] v);
    logic [14:0] r;
    for (int i = 0; i < 15; i++) r[i] = (int'(v) > i);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    check(ladder == expCode[11:0], {req, " ladder (R8)"}, 32'(ladder), 32'(expCode[11:0]));
    check(segEn == thermo(expCode[15:12]), {req, " segEn (R7)"}, 32'(segEn), 32'(thermo(expCode[15:12])));
  endtask

  // bits right-aligned, sent from bit n-1 down to bit 0
  task automatic sendFrame(input logic [31:0] bits, input int n);
    csN = 1'b0; #20;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i]; sclk = 1'b0; #20;
      sclk = 1'b1; #20;
    end
    sclk = 1'b0; #20;
    csN = 1'b1; #60;
  endtask

  task automatic frameAndCheck(input logic [31:0] bits, input int n, input string req);
    int expPulses;
    pulseCount = 0; highCycles = 0;
    sendFrame(bits, n);
    expPulses = (n >= 16) ? 1 : 0;
    if (n >= 16) expCode = bits[15:0];
    checkOutputs(req);
    check(pulseCount == expPulses, {req, " update pulses (R10)"}, 32'(pulseCount), 32'(expPulses));
    check(highCycles == expPulses, {req, " pulse width (R10)"}, 32'(highCycles), 32'(expPulses));
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      runCount++; failCount++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #20;
    // R9: state during reset
    check(segEn == 0 && ladder == 0 && !updated, "R9 in reset", {16'(segEn), ladder, 3'b0, updated}, 0);
    #20 rstN = 1'b1; #40;
    check(segEn == 0 && ladder == 0 && !updated, "R9 after release", {16'(segEn), ladder, 3'b0, updated}, 0);

    // R1 / R7 / R8 directed codes
    frameAndCheck(32'hFFFF, 16, "R1 full scale");
    frameAndCheck(32'h8001, 16, "R1 msb-first 8001");
    frameAndCheck(32'h1000, 16, "R7 one segment");
    frameAndCheck(32'h0000, 16, "R1 zero");
    frameAndCheck(32'hA5C3, 16, "R3 load A5C3");
    // R4: one bit short keeps A5C3
    frameAndCheck(32'h7FFF, 15, "R4 short frame");
    // R5: 20 bits, last 16 win
    frameAndCheck(32'hF_3C5A, 20, "R5 long frame");
    // R6: aborted 10-bit frame, then 8-bit frame must not load
    frameAndCheck(32'h3FF, 10, "R6 aborted frame");
    frameAndCheck(32'hFF, 8, "R6 restart count");

    // R2: serial clock activity while chip select is high
    pulseCount = 0; highCycles = 0;
    for (int i = 0; i < 24; i++) begin
      sdi = 1'($urandom); sclk = 1'b1; #20; sclk = 1'b0; #20;
    end
    #60;
    checkOutputs("R2 idle clocks");
    check(pulseCount == 0, "R2 no pulse while deselected", 32'(pulseCount), 0);

    // R7: each top nibble value
    for (int v = 0; v < 16; v++)
      frameAndCheck({16'h0, 4'(v), 12'($urandom)}, 16, "R7 nibble sweep");

    // random frame lengths and data
    for (int i = 0; i < 40; i++) begin
      int n = 1 + int'($urandom % 24);
      frameAndCheck($urandom, n, "R3 random frame");
    end

    finishRun();
  end
endmodule